// File: doc/BRIEF.md
# Receive Frame Error Filter and Commit

This block sits between a receive deserialiser and a byte-wide packet buffer. The stream reaching it has already lost its preamble. Each byte is written into the buffer right away, at a running write pointer. Alongside, the block counts the frame length and runs a CRC-32 over the bytes. A single end-of-frame cycle also reports how many dribble bits trailed the last whole byte.

When a frame ends, the block decides whether to keep it. A kept frame has its first free address published as the new committed head pointer, and a one-cycle status strobe reports its length and error flags. A rejected frame rolls the write pointer back to the committed head. The next frame then overwrites it, and downstream logic never sees it.

Two host mode inputs relax the filter. `keep_errored` admits frames with CRC, alignment or short-length errors. `keep_runts` admits short frames that have no other error. Frames below six bytes are never kept.

Top module: `rx_frame_filter`

## Requirements
- R1: After reset, `commit_ptr` and `buf_addr` are 0 and `stat_strobe` is 0.
- R2: Every cycle with `byte_valid` high and `frame_end` low produces `buf_we` high. On that cycle `buf_data` equals `byte_in`, and successive bytes go to consecutive addresses, starting at `commit_ptr` for each new frame.
- R3: "Frame length" means the bytes received minus the four trailing FCS bytes. When a frame is kept, `stat_len` reports this length.
- R4: The CRC is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones), run over data and FCS. The FCS is sent as the complement of the data CRC, least significant byte first. `stat_crc_err` is set when the bit-reversed final register differs from 0xC704DD7B.
- R5: A nonzero `dribble_bits` value on the `frame_end` cycle sets `stat_align_err`.
- R6: `stat_short_err` is set when the frame length is below 60.
- R7: A frame whose length is below 6 is always discarded, whatever the mode inputs.
- R8: With `keep_errored` low, a frame with a CRC or alignment error is discarded.
- R9: With both mode inputs low, an error-free frame of length 6 to 59 is discarded. With `keep_runts` high, it is kept.
- R10: With `keep_errored` high, any frame of length 6 or more is kept, and its CRC, alignment and short flags are reported.
- R11: On a kept frame, `stat_strobe` is high for exactly the one cycle after the `frame_end` cycle. In that same cycle `commit_ptr` moves to the address following the last stored byte.
- R12: On a discarded frame, `stat_strobe` stays low and `commit_ptr` does not change. In the cycle after `frame_end`, `buf_addr` is back at `commit_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keep_errored | input | 1 | Mode: keep frames with CRC, alignment or short errors |
| keep_runts | input | 1 | Mode: keep error-free frames of length 6 to 59 |
| byte_valid | input | 1 | A received byte is present |
| byte_in | input | 8 | Received byte |
| frame_end | input | 1 | End-of-frame cycle; a byte presented in this cycle is not stored |
| dribble_bits | input | 3 | Bits past the last whole byte, sampled with `frame_end` |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | AW | Buffer write address |
| buf_data | output | 8 | Buffer write data |
| commit_ptr | output | AW | Address following the last kept frame |
| stat_strobe | output | 1 | One-cycle strobe for a kept frame |
| stat_len | output | LW | Frame length, excluding FCS |
| stat_crc_err | output | 1 | CRC check failed |
| stat_align_err | output | 1 | Trailing dribble bits present |
| stat_short_err | output | 1 | Length below 60 |

## Verification
The case hardest to reach from the ports is a discarded frame: it leaves no strobe and no visible pointer change. The bench detects a failed rollback through the next frame. That frame's first write address must equal the unchanged `commit_ptr`, and its stored bytes must match exactly. To cover every combination, the bench sweeps frame lengths from 0 to 70 bytes. Each length is sent under all four mode settings with a clean frame, a corrupted FCS and trailing dribble bits, so the 6-byte and 60-byte edges are exercised in every mode.

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
  parameter int AW        = 11,
  parameter int LW        = 11,
  parameter int MIN_LEN   = 60,
  parameter int FLOOR_LEN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          keep_errored,
  input  logic          keep_runts,
  input  logic          byte_valid,
  input  logic [7:0]    byte_in,
  input  logic          frame_end,
  input  logic [2:0]    dribble_bits,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_data,
  output logic [AW-1:0] commit_ptr,
  output logic          stat_strobe,
  output logic [LW-1:0] stat_len,
  output logic          stat_crc_err,
  output logic          stat_align_err,
  output logic          stat_short_err
);
  localparam logic [31:0]   RESIDUE   = 32'hC704DD7B;
  localparam logic [LW-1:0] SHORT_TOT = LW'(MIN_LEN + 4);
  localparam logic [LW-1:0] FLOOR_TOT = LW'(FLOOR_LEN + 4);
  localparam logic [LW-1:0] CNT_MAX   = '1;

  logic [AW-1:0] wptr;
  logic [LW-1:0] cnt;
  logic [31:0]   crc, crc_nx, crc_rev;
  logic          e_crc, e_align, e_short, tiny, keep;

  always_comb begin
    crc_nx = crc ^ {24'd0, byte_in};
    for (int b = 0; b < 8; b++)
      crc_nx = crc_nx[0] ? ((crc_nx >> 1) ^ 32'hEDB88320) : (crc_nx >> 1);
  end

  always_comb
    for (int b = 0; b < 32; b++) crc_rev[b] = crc[31-b];

  assign e_crc   = crc_rev != RESIDUE;
  assign e_align = dribble_bits != 3'd0;
  assign e_short = cnt < SHORT_TOT;
  assign tiny    = cnt < FLOOR_TOT;
  assign keep    = !tiny &&
                   (keep_errored || (!e_crc && !e_align && (!e_short || keep_runts)));

  assign buf_we   = byte_valid && !frame_end;
  assign buf_addr = wptr;
  assign buf_data = byte_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr           <= '0;
      commit_ptr     <= '0;
      cnt            <= '0;
      crc            <= '1;
      stat_strobe    <= 1'b0;
      stat_len       <= '0;
      stat_crc_err   <= 1'b0;
      stat_align_err <= 1'b0;
      stat_short_err <= 1'b0;
    end else begin
      stat_strobe <= 1'b0;
      if (frame_end) begin
        cnt <= '0;
        crc <= '1;
        if (keep) begin
          commit_ptr     <= wptr;
          stat_strobe    <= 1'b1;
          stat_len       <= cnt - LW'(4);
          stat_crc_err   <= e_crc;
          stat_align_err <= e_align;
          stat_short_err <= e_short;
        end else begin
          wptr <= commit_ptr;
        end
      end else if (byte_valid) begin
        wptr <= wptr + AW'(1);
        cnt  <= (cnt == CNT_MAX) ? cnt : cnt + LW'(1);
        crc  <= crc_nx;
      end
    end
  end
endmodule

// File: rtl/rx_frame_filter_chk.sv
module rx_frame_filter_chk #(
  parameter int AW = 11,
  parameter int LW = 11,
  parameter int FLOOR_LEN = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          keep_errored,
  input logic          keep_runts,
  input logic          frame_end,
  input logic          buf_we,
  input logic [AW-1:0] buf_addr,
  input logic [AW-1:0] commit_ptr,
  input logic          stat_strobe,
  input logic [LW-1:0] stat_len,
  input logic          stat_crc_err,
  input logic          stat_align_err,
  input logic          stat_short_err
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_strobe |=> !stat_strobe); // R11
  AST_HEAD_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ptr != $past(commit_ptr)) |-> stat_strobe); // R12
  AST_FLOOR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    stat_strobe |-> (stat_len >= LW'(FLOOR_LEN))); // R7
  AST_ERR_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_strobe && (stat_crc_err || stat_align_err)) |-> $past(keep_errored)); // R8
  AST_SHORT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_strobe && stat_short_err) |-> ($past(keep_runts) || $past(keep_errored))); // R9
  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && $past(buf_we)) |-> (buf_addr == $past(buf_addr) + AW'(1))); // R2
  AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_end) && !stat_strobe) |-> (buf_addr == commit_ptr)); // R12
endmodule

bind rx_frame_filter rx_frame_filter_chk #(.AW(AW), .LW(LW), .FLOOR_LEN(FLOOR_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .keep_errored(keep_errored), .keep_runts(keep_runts),
  .frame_end(frame_end), .buf_we(buf_we), .buf_addr(buf_addr), .commit_ptr(commit_ptr),
  .stat_strobe(stat_strobe), .stat_len(stat_len), .stat_crc_err(stat_crc_err),
  .stat_align_err(stat_align_err), .stat_short_err(stat_short_err));

// File: tb/rx_frame_filter_test.sv
module rx_frame_filter_test;
  localparam int AW = 8;
  localparam int LW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic keep_errored = 1'b0, keep_runts = 1'b0;
  logic byte_valid = 1'b0, frame_end = 1'b0;
  logic [7:0] byte_in = 8'd0;
  logic [2:0] dribble_bits = 3'd0;
  logic buf_we;
  logic [AW-1:0] buf_addr, commit_ptr;
  logic [7:0] buf_data;
  logic stat_strobe, stat_crc_err, stat_align_err, stat_short_err;
  logic [LW-1:0] stat_len;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] mem [256];
  logic [7:0] frame [80];

  always #10 clk = ~clk;

  rx_frame_filter #(.AW(AW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .keep_errored(keep_errored), .keep_runts(keep_runts),
    .byte_valid(byte_valid), .byte_in(byte_in), .frame_end(frame_end),
    .dribble_bits(dribble_bits), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_data(buf_data), .commit_ptr(commit_ptr), .stat_strobe(stat_strobe),
    .stat_len(stat_len), .stat_crc_err(stat_crc_err), .stat_align_err(stat_align_err),
    .stat_short_err(stat_short_err));

  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_data;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, frame[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic send(input int len, input bit bad, input bit runt, input int err);
    logic [31:0] fcs;
    logic [AW-1:0] start;
    bit e_crc, e_al, e_sh, keep, same;
    int tot = len + 4;
    for (int i = 0; i < len; i++) frame[i] = 8'((len * 7 + i * 13 + 3) & 255);
    fcs = ~crc_of(len);
    if (err == 1) fcs[5] = ~fcs[5];
    for (int i = 0; i < 4; i++) frame[len + i] = fcs[8*i +: 8];
    e_crc = (err == 1); e_al = (err == 2); e_sh = (len < 60);
    keep = (len >= 6) && (bad || (!e_crc && !e_al && (!e_sh || runt)));
    start = commit_ptr;
    keep_errored = bad; keep_runts = runt;
    for (int i = 0; i < tot; i++) begin
      byte_valid = 1'b1; byte_in = frame[i];
      #1;
      if (i == 0) check(buf_we && buf_addr == start, "R2 first addr", buf_addr, start);
      @(negedge clk);
    end
    byte_valid = 1'b0; frame_end = 1'b1; dribble_bits = (err == 2) ? 3'd3 : 3'd0;
    @(negedge clk);
    frame_end = 1'b0; dribble_bits = 3'd0;
    if (keep) begin
      check(stat_strobe == 1'b1, "R10/R11 strobe", stat_strobe, 1);
      check(commit_ptr == AW'(start + tot), "R11 commit_ptr", commit_ptr, AW'(start + tot));
      check(stat_len == LW'(len), "R3 len", stat_len, len);
      check(stat_crc_err == e_crc, "R4 crc flag", stat_crc_err, e_crc);
      check(stat_align_err == e_al, "R5 align flag", stat_align_err, e_al);
      check(stat_short_err == e_sh, "R6 short flag", stat_short_err, e_sh);
      same = 1;
      for (int i = 0; i < tot; i++) if (mem[AW'(start + i)] != frame[i]) same = 0;
      check(same, "R2 stored bytes", same, 1);
    end else begin
      check(stat_strobe == 1'b0, (len < 6) ? "R7 tiny discard" :
            (e_crc || e_al) ? "R8 errored discard" : "R9 short discard", stat_strobe, 0);
      check(commit_ptr == start, "R12 commit_ptr kept", commit_ptr, start);
      check(buf_addr == start, "R12 rewind", buf_addr, start);
    end
    @(negedge clk);
    check(stat_strobe == 1'b0, "R11 strobe width", stat_strobe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(commit_ptr == 0 && buf_addr == 0, "R1 reset ptrs", commit_ptr, 0);
    check(stat_strobe == 0, "R1 reset strobe", stat_strobe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int len = 0; len <= 70; len++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 3; e++)
          send(len, m[1], m[0], e);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule